// File: doc/BRIEF.md
# Linked-Tag DMA Chain Sequencer

This block is the control sequencer of one DMA channel. In its direct mode it issues a single data burst built from a preloaded quadword count and a preloaded data address. In its chained mode it walks a linked list of 128-bit descriptors held in memory. For each descriptor it fetches the descriptor, unpacks it, loads the count and the data address, and can forward the descriptor itself downstream. It then issues the data burst and decides whether to fetch the next descriptor or to finish.

A start pulse loads the control, count, data-address and descriptor-address registers and sets the busy bit inside the control register. Every request leaves the block on a valid/ready handshake. The descriptor response returns one cycle or more later, with an error flag. Finishing clears the busy bit and raises a one-cycle interrupt. A chain finishes on an end descriptor, or on a descriptor that requests an interrupt while the control register enables it. The interleaved transfer mode is served by other logic, so this block refuses to start in that mode.

Top module: `dma_chain_seq`

## Requirements
- R1: While reset is asserted and right after it, busy, irq, every request valid, the control register, the count and the bus-error flag read zero.
- R2: With control bits 3:2 equal to 00 (direct), a start issues exactly one burst at the preloaded address with the preloaded count and no descriptor fetch. Afterwards the data address has advanced by count×16 and the count reads zero.
- R3: A descriptor is decoded as follows. Bits 15:0 are the count, bits 30:28 the ID, bit 31 the interrupt request, and bits 63:32 the data address. Bits 31:16 of the descriptor replace bits 31:16 of the control register, and bits 15:0 keep their value.
- R4: With control bits 3:2 equal to 01 (chained), an ID of 7 finishes the channel after its burst. Any other ID fetches the next descriptor at the previous descriptor address + 16 + count×16.
- R5: A descriptor with ID 0 sets the stall address output to its data address + count×16.
- R6: When control bit 7 is set and descriptor bit 31 is set, the chain finishes after that burst with the count at zero. When control bit 7 is clear, descriptor bit 31 has no effect.
- R7: When control bit 6 is set, the whole 128-bit descriptor is presented on the forward port before its data burst.
- R8: In chained mode, a non-zero preloaded count is burst first at the preloaded address, before the first descriptor fetch.
- R9: A descriptor response flagged as an error finishes the channel without a burst and sets the sticky bus-error flag. The flag is cleared by the next accepted start.
- R10: On finishing, irq is high for exactly one cycle while busy (control bit 8) is still set. Busy is clear from the next cycle on.
- R11: A start with control bits 3:2 equal to 10 or 11 is ignored: busy stays clear and no request is made.
- R12: A descriptor with a count of zero produces no burst.
- R13: A request valid stays high, with its payload unchanged, until ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start pulse, taken only when idle |
| ctrl_in | input | 32 | Control value loaded on start |
| cnt_in | input | 16 | Preloaded quadword count |
| daddr_in | input | 32 | Preloaded data address |
| taddr_in | input | 32 | First descriptor address |
| tag_req_valid | output | 1 | Descriptor fetch request |
| tag_req_ready | input | 1 | Fetch request accepted |
| tag_req_addr | output | 32 | Descriptor address |
| tag_rsp_valid | input | 1 | Descriptor response strobe |
| tag_rsp_err | input | 1 | Descriptor fetch failed |
| tag_rsp_data | input | 128 | Descriptor contents |
| fwd_valid | output | 1 | Descriptor forward request |
| fwd_ready | input | 1 | Forward accepted |
| fwd_tag | output | 128 | Descriptor being forwarded |
| burst_valid | output | 1 | Data burst request |
| burst_ready | input | 1 | Burst accepted |
| burst_addr | output | 32 | Burst start address |
| burst_qwc | output | 16 | Burst length in quadwords |
| ctrl_out | output | 32 | Channel control register |
| cnt_out | output | 16 | Count register |
| daddr_out | output | 32 | Data address register |
| taddr_out | output | 32 | Descriptor address register |
| stall_addr | output | 32 | Stall address |
| buserr | output | 1 | Sticky descriptor bus-error flag |
| busy | output | 1 | Channel busy (control bit 8) |
| irq | output | 1 | Completion interrupt pulse |

## Verification
A wrong state in the sequencer shows up at the ports within a few cycles of the descriptor that triggers it. A wrong descriptor address is seen on the next fetch request. A wrong stop decision is seen as an extra or a missing fetch before irq. A count or address that is not advanced shows on burst_addr and burst_qwc, or in the register outputs once irq has fired. The bench records every accepted fetch, forward and burst in order and compares the recorded sequence against the descriptor lists it wrote. A stalling burst_ready checks that requests are held, and the busy bit is observed around irq to check the completion timing.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int CTRL_W   = 32;
  localparam int BIT_BUSY = 8;
  localparam int BIT_TIE  = 7;
  localparam int BIT_TTE  = 6;
  localparam logic [1:0] MODE_DIRECT = 2'b00;
  localparam logic [1:0] MODE_CHAIN  = 2'b01;
  localparam logic [2:0] ID_STALL = 3'd0;
  localparam logic [2:0] ID_END   = 3'd7;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_DECODE, S_SEND, S_BURST, S_CHECK, S_DONE
  } dcs_state_e;
endpackage

// File: rtl/dcs_tag_unpack.sv
module dcs_tag_unpack #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int TW = 128
) (
  input  logic [TW-1:0] tag,
  output logic [CW-1:0] qwc,
  output logic [2:0]    id,
  output logic          irq_req,
  output logic [15:0]   ctrl_hi,
  output logic [AW-1:0] addr
);
  // word 0: count low, id, irq; word 1: data address
  assign qwc     = tag[CW-1:0];
  assign id      = tag[30:28];
  assign irq_req = tag[31];
  assign ctrl_hi = tag[31:16];
  assign addr    = tag[32 +: AW];
endmodule

// File: rtl/dcs_addr_step.sv
module dcs_addr_step #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic [AW-1:0] base,
  input  logic [CW-1:0] qwc,
  input  logic          add_tag,
  output logic [AW-1:0] sum
);
  localparam int QW_SHIFT = 4;
  localparam logic [AW-1:0] TAG_BYTES = AW'(16);

  logic [AW-1:0] data_bytes;
  assign data_bytes = AW'(qwc) << QW_SHIFT;
  assign sum = base + data_bytes + (add_tag ? TAG_BYTES : '0);
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
  import dcs_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int TW = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [CTRL_W-1:0] ctrl_in,
  input  logic [CW-1:0]     cnt_in,
  input  logic [AW-1:0]     daddr_in,
  input  logic [AW-1:0]     taddr_in,
  output logic              tag_req_valid,
  input  logic              tag_req_ready,
  output logic [AW-1:0]     tag_req_addr,
  input  logic              tag_rsp_valid,
  input  logic              tag_rsp_err,
  input  logic [TW-1:0]     tag_rsp_data,
  output logic              fwd_valid,
  input  logic              fwd_ready,
  output logic [TW-1:0]     fwd_tag,
  output logic              burst_valid,
  input  logic              burst_ready,
  output logic [AW-1:0]     burst_addr,
  output logic [CW-1:0]     burst_qwc,
  output logic [CTRL_W-1:0] ctrl_out,
  output logic [CW-1:0]     cnt_out,
  output logic [AW-1:0]     daddr_out,
  output logic [AW-1:0]     taddr_out,
  output logic [AW-1:0]     stall_addr,
  output logic              buserr,
  output logic              busy,
  output logic              irq
);

  // reset: asynchronous assertion, synchronous release
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  dcs_state_e        state_q, state_d;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [AW-1:0]     daddr_q, daddr_d, taddr_q, taddr_d, stall_q, stall_d;
  logic [2:0]        id_q, id_d;
  logic              tirq_q, tirq_d, seen_q, seen_d, err_q, err_d;
  logic [TW-1:0]     tag_q;
  logic              tag_ld;

  logic [CW-1:0] dec_qwc;
  logic [2:0]    dec_id;
  logic          dec_irq;
  logic [15:0]   dec_hi;
  logic [AW-1:0] dec_addr;
  logic [AW-1:0] data_next, tag_next, stall_calc;

  dcs_tag_unpack #(.AW(AW), .CW(CW), .TW(TW)) u_unpack (
    .tag(tag_rsp_data), .qwc(dec_qwc), .id(dec_id), .irq_req(dec_irq),
    .ctrl_hi(dec_hi), .addr(dec_addr)
  );

  dcs_addr_step #(.AW(AW), .CW(CW)) u_data_step (
    .base(daddr_q), .qwc(cnt_q), .add_tag(1'b0), .sum(data_next)
  );

  dcs_addr_step #(.AW(AW), .CW(CW)) u_tag_step (
    .base(taddr_q), .qwc(tag_q[CW-1:0]), .add_tag(1'b1), .sum(tag_next)
  );

  dcs_addr_step #(.AW(AW), .CW(CW)) u_stall_step (
    .base(dec_addr), .qwc(dec_qwc), .add_tag(1'b0), .sum(stall_calc)
  );

  logic [1:0] go_mode, run_mode;
  logic       stop_now;
  assign go_mode  = ctrl_in[3:2];
  assign run_mode = ctrl_q[3:2];
  assign stop_now = (id_q == ID_END) || (ctrl_q[BIT_TIE] && tirq_q);

  always_comb begin
    state_d = state_q;
    ctrl_d  = ctrl_q;
    cnt_d   = cnt_q;
    daddr_d = daddr_q;
    taddr_d = taddr_q;
    stall_d = stall_q;
    id_d    = id_q;
    tirq_d  = tirq_q;
    seen_d  = seen_q;
    err_d   = err_q;
    tag_ld  = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (go && (go_mode == MODE_DIRECT || go_mode == MODE_CHAIN)) begin
          ctrl_d           = ctrl_in;
          ctrl_d[BIT_BUSY] = 1'b1;
          cnt_d   = cnt_in;
          daddr_d = daddr_in;
          taddr_d = taddr_in;
          err_d   = 1'b0;
          seen_d  = 1'b0;
          if (cnt_in != '0)               state_d = S_BURST;
          else if (go_mode == MODE_CHAIN) state_d = S_FETCH;
          else                            state_d = S_DONE;
        end
      end
      S_FETCH: begin
        if (tag_req_ready) state_d = S_DECODE;
      end
      S_DECODE: begin
        if (tag_rsp_valid) begin
          if (tag_rsp_err) begin
            err_d   = 1'b1;
            state_d = S_DONE;
          end else begin
            ctrl_d  = {dec_hi, ctrl_q[15:0]};
            cnt_d   = dec_qwc;
            daddr_d = dec_addr;
            id_d    = dec_id;
            tirq_d  = dec_irq;
            seen_d  = 1'b1;
            tag_ld  = 1'b1;
            if (dec_id == ID_STALL) stall_d = stall_calc;
            if (ctrl_q[BIT_TTE])     state_d = S_SEND;
            else if (dec_qwc != '0)  state_d = S_BURST;
            else                     state_d = S_CHECK;
          end
        end
      end
      S_SEND: begin
        if (fwd_ready) state_d = (cnt_q != '0) ? S_BURST : S_CHECK;
      end
      S_BURST: begin
        if (burst_ready) begin
          daddr_d = data_next;
          cnt_d   = '0;
          state_d = (run_mode == MODE_DIRECT) ? S_DONE : S_CHECK;
        end
      end
      S_CHECK: begin
        if (!seen_q) begin
          state_d = S_FETCH;
        end else if (stop_now) begin
          cnt_d   = '0;
          state_d = S_DONE;
        end else begin
          taddr_d = tag_next;
          state_d = S_FETCH;
        end
      end
      S_DONE: begin
        ctrl_d[BIT_BUSY] = 1'b0;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      state_q <= S_IDLE;
      ctrl_q  <= '0;
      cnt_q   <= '0;
      daddr_q <= '0;
      taddr_q <= '0;
      stall_q <= '0;
      id_q    <= '0;
      tirq_q  <= 1'b0;
      seen_q  <= 1'b0;
      err_q   <= 1'b0;
      tag_q   <= '0;
    end else begin
      state_q <= state_d;
      ctrl_q  <= ctrl_d;
      cnt_q   <= cnt_d;
      daddr_q <= daddr_d;
      taddr_q <= taddr_d;
      stall_q <= stall_d;
      id_q    <= id_d;
      tirq_q  <= tirq_d;
      seen_q  <= seen_d;
      err_q   <= err_d;
      if (tag_ld) tag_q <= tag_rsp_data;
    end
  end

  assign tag_req_valid = (state_q == S_FETCH);
  assign tag_req_addr  = taddr_q;
  assign fwd_valid     = (state_q == S_SEND);
  assign fwd_tag       = tag_q;
  assign burst_valid   = (state_q == S_BURST);
  assign burst_addr    = daddr_q;
  assign burst_qwc     = cnt_q;
  assign ctrl_out      = ctrl_q;
  assign cnt_out       = cnt_q;
  assign daddr_out     = daddr_q;
  assign taddr_out     = taddr_q;
  assign stall_addr    = stall_q;
  assign buserr        = err_q;
  assign busy          = ctrl_q[BIT_BUSY];
  assign irq           = (state_q == S_DONE);

  a_r13_burst_hold: assert property (@(posedge clk) disable iff (!rst_sync_q)
    burst_valid && !burst_ready |=> burst_valid && $stable(burst_addr) && $stable(burst_qwc));
  a_r13_fetch_hold: assert property (@(posedge clk) disable iff (!rst_sync_q)
    tag_req_valid && !tag_req_ready |=> tag_req_valid && $stable(tag_req_addr));
  a_r13_one_request: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $onehot0({tag_req_valid, fwd_valid, burst_valid}));
  a_r10_irq_while_busy: assert property (@(posedge clk) disable iff (!rst_sync_q)
    irq |-> busy);
  a_r10_irq_single: assert property (@(posedge clk) disable iff (!rst_sync_q)
    irq |=> !irq && !busy);
  a_r12_no_empty_burst: assert property (@(posedge clk) disable iff (!rst_sync_q)
    burst_valid |-> burst_qwc != '0);
  a_r11_interleave_refused: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (state_q == S_IDLE) && go && ctrl_in[3] |=> !busy);
  a_r9_error_ends: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (state_q == S_DECODE) && tag_rsp_valid && tag_rsp_err |=> irq && buserr);

endmodule

// File: tb/tb_dma_chain_seq.sv
module tb_dma_chain_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic         go = 1'b0;
  logic [31:0]  ctrl_in = '0;
  logic [15:0]  cnt_in = '0;
  logic [31:0]  daddr_in = '0, taddr_in = '0;
  logic         tag_req_valid, tag_rsp_valid = 1'b0, tag_rsp_err = 1'b0;
  logic         tag_req_ready = 1'b1;
  logic [31:0]  tag_req_addr;
  logic [127:0] tag_rsp_data = '0;
  logic         fwd_valid, fwd_ready = 1'b1;
  logic [127:0] fwd_tag;
  logic         burst_valid, burst_ready = 1'b1;
  logic [31:0]  burst_addr;
  logic [15:0]  burst_qwc;
  logic [31:0]  ctrl_out, daddr_out, taddr_out, stall_addr;
  logic [15:0]  cnt_out;
  logic         buserr, busy, irq;

  dma_chain_seq dut (
    .clk(clk), .rst_n(rst_n), .go(go), .ctrl_in(ctrl_in), .cnt_in(cnt_in),
    .daddr_in(daddr_in), .taddr_in(taddr_in),
    .tag_req_valid(tag_req_valid), .tag_req_ready(tag_req_ready), .tag_req_addr(tag_req_addr),
    .tag_rsp_valid(tag_rsp_valid), .tag_rsp_err(tag_rsp_err), .tag_rsp_data(tag_rsp_data),
    .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_tag(fwd_tag),
    .burst_valid(burst_valid), .burst_ready(burst_ready), .burst_addr(burst_addr),
    .burst_qwc(burst_qwc), .ctrl_out(ctrl_out), .cnt_out(cnt_out), .daddr_out(daddr_out),
    .taddr_out(taddr_out), .stall_addr(stall_addr), .buserr(buserr), .busy(busy), .irq(irq)
  );

  int checks = 0, fails = 0, cycles = 0;
  logic [127:0] tagmem [0:15];
  logic [31:0]  err_addr = 32'hFFFF_FFF0;
  logic         stall_mode = 1'b0;
  int nb = 0, nf = 0, nt = 0, irqs = 0, irq_run = 0, irq_max = 0, nb_first_tag = -1;
  logic [31:0]  lb_addr [0:15];
  logic [15:0]  lb_qwc  [0:15];
  logic [31:0]  lt_addr [0:15];
  logic [127:0] lf_tag  [0:7];

  // memory model and monitor
  always @(posedge clk) begin
    tag_rsp_valid <= tag_req_valid && tag_req_ready;
    tag_rsp_data  <= tagmem[tag_req_addr[7:4]];
    tag_rsp_err   <= (tag_req_addr == err_addr);
    burst_ready   <= stall_mode ? ~burst_ready : 1'b1;
    if (rst_n) begin
      if (tag_req_valid && tag_req_ready) begin
        if (nt == 0) nb_first_tag = nb;
        if (nt < 16) lt_addr[nt] = tag_req_addr;
        nt++;
      end
      if (burst_valid && burst_ready) begin
        if (nb < 16) begin lb_addr[nb] = burst_addr; lb_qwc[nb] = burst_qwc; end
        nb++;
      end
      if (fwd_valid && fwd_ready) begin
        if (nf < 8) lf_tag[nf] = fwd_tag;
        nf++;
      end
      if (irq) begin irqs++; irq_run++; if (irq_run > irq_max) irq_max = irq_run; end
      else irq_run = 0;
    end
  end

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] mk(input logic irqb, input logic [2:0] id,
      input logic [11:0] hi, input logic [15:0] q, input logic [31:0] a);
    return {32'hC0DE_0000 | {16'h0, q}, 32'h5A5A_0000 | {20'h0, hi}, a, irqb, id, hi, q};
  endfunction

  task automatic clr_logs();
    nb = 0; nf = 0; nt = 0; irqs = 0; irq_max = 0; nb_first_tag = -1;
  endtask

  task automatic start(input logic [31:0] c, input logic [15:0] n,
                       input logic [31:0] d, input logic [31:0] t);
    clr_logs();
    @(negedge clk);
    ctrl_in = c; cnt_in = n; daddr_in = d; taddr_in = t; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (irqs == 0 && n < 2000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0); chk("R1 irq", irq, 0);
    chk("R1 valids", {tag_req_valid, fwd_valid, burst_valid}, 0);
    chk("R1 ctrl", ctrl_out, 0); chk("R1 cnt", cnt_out, 0); chk("R1 buserr", buserr, 0);
  endtask

  task automatic t_direct();
    start(32'h0000_0000, 16'd3, 32'h1000, 32'h0);
    chk("R10 busy after start", busy, 1);
    wait_done();
    chk("R2 one burst", nb, 1);
    chk("R2 burst addr", lb_addr[0], 32'h1000);
    chk("R2 burst qwc", lb_qwc[0], 3);
    chk("R2 no fetch", nt, 0);
    chk("R2 addr advanced", daddr_out, 32'h1030);
    chk("R2 count zero", cnt_out, 0);
    chk("R9 flag cleared by start", buserr, 0);
    chk("R10 one irq", irqs, 1); chk("R10 irq width", irq_max, 1);
    chk("R10 busy cleared", busy, 0); chk("R10 ctrl bit8", ctrl_out[8], 0);
  endtask

  task automatic t_chain();
    tagmem[0] = mk(0, 3'd1, 12'h123, 16'd2, 32'h2000);
    tagmem[3] = mk(0, 3'd0, 12'h456, 16'd1, 32'h3000);
    tagmem[5] = mk(0, 3'd7, 12'hABC, 16'd4, 32'h4000);
    stall_mode = 1'b1;
    start(32'h0000_0004, 16'd0, 32'h0, 32'h100);
    wait_done();
    stall_mode = 1'b0;
    chk("R4 fetch count", nt, 3);
    chk("R4 second tag addr", lt_addr[1], 32'h130);
    chk("R4 third tag addr", lt_addr[2], 32'h150);
    chk("R3 bursts", nb, 3);
    chk("R3 burst0", {lb_addr[0], lb_qwc[0]}, {32'h2000, 16'd2});
    chk("R3 burst1", {lb_addr[1], lb_qwc[1]}, {32'h3000, 16'd1});
    chk("R3 burst2", {lb_addr[2], lb_qwc[2]}, {32'h4000, 16'd4});
    chk("R5 stall addr", stall_addr, 32'h3010);
    chk("R3 ctrl upper copied lower kept", ctrl_out, 32'h7ABC_0004);
    chk("R4 end leaves tag addr", taddr_out, 32'h150);
    chk("R4 final data addr", daddr_out, 32'h4040);
    chk("R10 one irq", irqs, 1);
  endtask

  task automatic t_forward();
    tagmem[0] = mk(0, 3'd1, 12'h0, 16'd1, 32'h6000);
    tagmem[2] = mk(0, 3'd7, 12'h0, 16'd0, 32'h7000);
    start(32'h0000_0044, 16'd0, 32'h0, 32'h200);
    wait_done();
    chk("R7 forwards", nf, 2);
    chk("R7 tag0", lf_tag[0], tagmem[0]);
    chk("R7 tag1", lf_tag[1], tagmem[2]);
    chk("R12 zero count no burst", nb, 1);
    chk("R12 data addr unchanged", daddr_out, 32'h7000);
  endtask

  task automatic t_tag_irq();
    tagmem[0] = mk(1, 3'd1, 12'h0, 16'd2, 32'h8000);
    tagmem[3] = mk(0, 3'd7, 12'h0, 16'd1, 32'h9000);
    start(32'h0000_0084, 16'd0, 32'h0, 32'h300);
    wait_done();
    chk("R6 stop after one tag", nt, 1);
    chk("R6 one burst", nb, 1);
    chk("R6 count zero", cnt_out, 0);
    chk("R6 tag addr kept", taddr_out, 32'h300);
    start(32'h0000_0004, 16'd0, 32'h0, 32'h300);
    wait_done();
    chk("R6 disabled bit ignored", nt, 2);
    chk("R6 disabled bursts", nb, 2);
  endtask

  task automatic t_preload();
    tagmem[0] = mk(0, 3'd7, 12'h0, 16'd1, 32'hA000);
    start(32'h0000_0004, 16'd2, 32'h5000, 32'h400);
    wait_done();
    chk("R8 preload burst first", {lb_addr[0], lb_qwc[0]}, {32'h5000, 16'd2});
    chk("R8 fetch after burst", nb_first_tag, 1);
    chk("R8 tag burst", {lb_addr[1], lb_qwc[1]}, {32'hA000, 16'd1});
  endtask

  task automatic t_buserr();
    err_addr = 32'h500;
    start(32'h0000_0004, 16'd0, 32'h0, 32'h500);
    wait_done();
    err_addr = 32'hFFFF_FFF0;
    chk("R9 flag", buserr, 1);
    chk("R9 no burst", nb, 0);
    chk("R9 irq", irqs, 1);
    chk("R9 busy clear", busy, 0);
  endtask

  task automatic t_interleave();
    start(32'h0000_0008, 16'd4, 32'hB000, 32'h600);
    repeat (20) @(negedge clk);
    chk("R11 busy", busy, 0);
    chk("R11 no requests", {nt, nb}, 0);
    chk("R11 no irq", irqs, 0);
    start(32'h0000_000C, 16'd4, 32'hB000, 32'h600);
    repeat (20) @(negedge clk);
    chk("R11 mode 11", {busy, nt, nb, irqs}, 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) tagmem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_buserr();
    t_direct();
    t_chain();
    t_forward();
    t_tag_irq();
    t_preload();
    t_interleave();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule